// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds several physical copies of one register behind a single bus offset. A second offset holds a steering selector with a group field, an instance field and a broadcast flag. With the broadcast flag set, a write to the shared offset loads every live copy at once. With the flag clear, the write reaches only the copy the selector points at. A read of the shared offset always returns just the steered copy, whatever the flag says.

Each copy has two status inputs, a presence (fuse) bit and a power bit, and counts as live only when both are high. An access aimed at a copy that is not live is terminated. A terminated read returns zero, and a terminated unicast write is dropped without any sign. A selector value that names no copy at all is handled the same way. A copy that is not live keeps its contents, so once it comes back it shows the value it had before.

The bus port is a single-request slave. Each request is either a read or a write. Read data comes back on the next clock with a one-cycle valid pulse.

Top module: `rsb_steered_bank`

## Requirements
- R1: After reset the selector reads back as 0x8000_0000 (broadcast flag set, group 0, instance 0) and every copy holds zero.
- R2: The selector sits at offset 0x00. The instance field is bits [3:0], the group field is bits [11:8] and the broadcast flag is bit 31. All other bits are ignored on write and read back as zero.
- R3: The replicated register sits at offset 0x04. The steered copy index is group * COPIES_PER_GROUP + instance, and a read returns that copy.
- R4: A write to offset 0x04 with the broadcast flag set loads the write data into every live copy.
- R5: A broadcast write leaves every copy that is not live unchanged.
- R6: A write to offset 0x04 with the broadcast flag clear changes only the steered copy.
- R7: A unicast write steered to a copy that is not live changes no copy.
- R8: A read steered to a copy that is not live returns zero, whether the broadcast flag is set or clear.
- R9: A selector whose instance is at least COPIES_PER_GROUP, or whose group is at least NUM_GROUPS, is terminated: reads return zero and unicast writes change no copy.
- R10: Every read request produces rvalid high on the following cycle with the data, and rvalid is low after any cycle with no read. A read of any offset other than 0x00 and 0x04 returns zero.
- R11: A copy is live only when both its presence bit and its power bit are high. A copy keeps its value while not live and reads that value again once live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| present_i | input | N_COPIES | Per-copy presence (fuse) bit |
| powered_i | input | N_COPIES | Per-copy power bit |
| rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| rdata_o | output | DATA_W | Read data |

## Verification
The assertions assume that the presence and power inputs, the request and the address are stable around the clock edge. They also assume that a broadcast write's data is the value later seen in each live copy. The bench therefore changes every input only on the falling edge and holds it for a full cycle. The bench never changes the live inputs in the same cycle as a request. This keeps the one-cycle checks on copy contents and read data well defined. Copies that are not live are observed by bringing them back to life and reading them through the normal steered read.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned INST_LSB = 0;
  localparam int unsigned GRP_LSB  = 8;
  localparam int unsigned MC_BIT   = 31;
  localparam int unsigned SEL_W    = 32;

  typedef struct packed {
    logic               mcast;
    logic [FIELD_W-1:0] grp;
    logic [FIELD_W-1:0] inst;
  } steer_t;

  localparam steer_t STEER_RESET = '{mcast: 1'b1, grp: '0, inst: '0};

  function automatic steer_t unpack_sel(input logic [SEL_W-1:0] w);
    steer_t s;
    s.mcast = w[MC_BIT];
    s.grp   = w[GRP_LSB +: FIELD_W];
    s.inst  = w[INST_LSB +: FIELD_W];
    return s;
  endfunction

  function automatic logic [SEL_W-1:0] pack_sel(input steer_t s);
    logic [SEL_W-1:0] w;
    w = '0;
    w[MC_BIT] = s.mcast;
    w[GRP_LSB +: FIELD_W] = s.grp;
    w[INST_LSB +: FIELD_W] = s.inst;
    return w;
  endfunction

  function automatic logic steer_exists(input steer_t s, input int unsigned n_groups,
                                        input int unsigned per_grp);
    return (32'(s.grp) < n_groups) && (32'(s.inst) < per_grp);
  endfunction

  function automatic int unsigned flat_index(input steer_t s, input int unsigned per_grp);
    return 32'(s.grp) * per_grp + 32'(s.inst);
  endfunction
endpackage

// File: rtl/rsb_selector.sv
module rsb_selector
  import rsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] wdata,
  output steer_t           sel_q,
  output logic [SEL_W-1:0] sel_word
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= STEER_RESET;
    else if (load) sel_q <= unpack_sel(wdata);
  end

  assign sel_word = pack_sel(sel_q);
endmodule

// File: rtl/rsb_target_decode.sv
module rsb_target_decode
  import rsb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS       = 4,
  parameter int unsigned COPIES_PER_GROUP = 2,
  localparam int unsigned N_COPIES = NUM_GROUPS * COPIES_PER_GROUP,
  localparam int unsigned IDX_W    = (N_COPIES > 1) ? $clog2(N_COPIES) : 1
)(
  input  steer_t              sel,
  input  logic [N_COPIES-1:0] alive,
  output logic [IDX_W-1:0]    tgt_idx,
  output logic                tgt_exists,
  output logic                tgt_live,
  output logic [N_COPIES-1:0] tgt_onehot
);
  assign tgt_exists = steer_exists(sel, NUM_GROUPS, COPIES_PER_GROUP);
  assign tgt_idx    = tgt_exists ? IDX_W'(flat_index(sel, COPIES_PER_GROUP)) : '0;

  for (genvar i = 0; i < N_COPIES; i++) begin : g_hot
    assign tgt_onehot[i] = tgt_exists && (32'(tgt_idx) == i);
  end

  assign tgt_live = |(tgt_onehot & alive);
endmodule

// File: rtl/rsb_copy_bank.sv
module rsb_copy_bank #(
  parameter int unsigned N_COPIES = 8,
  parameter int unsigned DATA_W   = 32
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_COPIES-1:0]              copy_we,
  input  logic [DATA_W-1:0]                wdata,
  output logic [N_COPIES-1:0][DATA_W-1:0]  copy_q
);
  for (genvar i = 0; i < N_COPIES; i++) begin : g_copy
    always_ff @(posedge clk) begin
      if (!rst_n)          copy_q[i] <= '0;
      else if (copy_we[i]) copy_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/rsb_steered_bank.sv
module rsb_steered_bank
  import rsb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS       = 4,
  parameter int unsigned COPIES_PER_GROUP = 2,
  parameter int unsigned DATA_W           = 32,
  parameter int unsigned ADDR_W           = 8,
  parameter logic [7:0]  SEL_OFS          = 8'h00,
  parameter logic [7:0]  REP_OFS          = 8'h04,
  localparam int unsigned N_COPIES = NUM_GROUPS * COPIES_PER_GROUP,
  localparam int unsigned IDX_W    = (N_COPIES > 1) ? $clog2(N_COPIES) : 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [N_COPIES-1:0] present_i,
  input  logic [N_COPIES-1:0] powered_i,
  output logic                rvalid_o,
  output logic [DATA_W-1:0]   rdata_o
);
  // bus decode, brought out for the checker
  logic hit_sel, hit_rep, wr_sel, wr_rep, rd_req;
  assign hit_sel = (addr_i == ADDR_W'(SEL_OFS));
  assign hit_rep = (addr_i == ADDR_W'(REP_OFS));
  assign wr_sel  = req_i &&  we_i && hit_sel;
  assign wr_rep  = req_i &&  we_i && hit_rep;
  assign rd_req  = req_i && !we_i;

  logic [N_COPIES-1:0] alive;
  assign alive = present_i & powered_i;

  steer_t           sel_q;
  logic [SEL_W-1:0] sel_word;
  logic             sel_mcast;

  rsb_selector u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_sel),
    .wdata    (wdata_i[SEL_W-1:0]),
    .sel_q    (sel_q),
    .sel_word (sel_word)
  );
  assign sel_mcast = sel_q.mcast;

  logic [IDX_W-1:0]    tgt_idx;
  logic                tgt_exists, tgt_live;
  logic [N_COPIES-1:0] tgt_onehot;

  rsb_target_decode #(
    .NUM_GROUPS       (NUM_GROUPS),
    .COPIES_PER_GROUP (COPIES_PER_GROUP)
  ) u_dec (
    .sel        (sel_q),
    .alive      (alive),
    .tgt_idx    (tgt_idx),
    .tgt_exists (tgt_exists),
    .tgt_live   (tgt_live),
    .tgt_onehot (tgt_onehot)
  );

  // per-copy write enables: broadcast to live copies, or one live target
  logic [N_COPIES-1:0] copy_we;
  always_comb begin
    copy_we = '0;
    if (wr_rep) begin
      if (sel_mcast) copy_we = alive;
      else           copy_we = tgt_onehot & alive;
    end
  end

  logic [N_COPIES-1:0][DATA_W-1:0] copy_q;

  rsb_copy_bank #(
    .N_COPIES (N_COPIES),
    .DATA_W   (DATA_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .copy_we (copy_we),
    .wdata   (wdata_i),
    .copy_q  (copy_q)
  );

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_sel)                  rd_mux = DATA_W'(sel_word);
    else if (hit_rep && tgt_live) rd_mux = copy_q[tgt_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      rdata_o  <= rd_req ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/rsb_steered_bank_chk.sv
module rsb_steered_bank_chk #(
  parameter int unsigned N_COPIES = 8,
  parameter int unsigned DATA_W   = 32
)(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            rd_req,
  input logic                            wr_rep,
  input logic                            hit_rep,
  input logic                            sel_mcast,
  input logic                            tgt_live,
  input logic                            tgt_exists,
  input logic [N_COPIES-1:0]             alive,
  input logic [N_COPIES-1:0]             copy_we,
  input logic [N_COPIES-1:0][DATA_W-1:0] copy_q,
  input logic [DATA_W-1:0]               wdata_i,
  input logic                            rvalid_o,
  input logic [DATA_W-1:0]               rdata_o
);
  // R6
  unicast_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rep && !sel_mcast) |-> $onehot0(copy_we));

  // R9
  missing_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rep && !sel_mcast && !tgt_exists) |-> (copy_we == '0));

  // R8
  term_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && hit_rep && !tgt_live) |=> (rdata_o == '0));

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rvalid_o);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rvalid_o);

  for (genvar i = 0; i < N_COPIES; i++) begin : g_cp
    // R4
    mcast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rep && sel_mcast && alive[i]) |=> (copy_q[i] == $past(wdata_i)));

    // R5
    dead_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alive[i] |=> $stable(copy_q[i]));
  end
endmodule

bind rsb_steered_bank rsb_steered_bank_chk #(
  .N_COPIES (N_COPIES),
  .DATA_W   (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .wr_rep     (wr_rep),
  .hit_rep    (hit_rep),
  .sel_mcast  (sel_mcast),
  .tgt_live   (tgt_live),
  .tgt_exists (tgt_exists),
  .alive      (alive),
  .copy_we    (copy_we),
  .copy_q     (copy_q),
  .wdata_i    (wdata_i),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o)
);

// File: tb/tb_rsb_steered_bank.sv
`timescale 1ns/1ps
module tb_rsb_steered_bank;
  localparam int NG = 4;
  localparam int PG = 2;
  localparam int NC = NG * PG;
  localparam logic [7:0] A_SEL = 8'h00;
  localparam logic [7:0] A_REP = 8'h04;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [NC-1:0] present = '1, powered = '1;
  logic          rvalid;
  logic [31:0]   rdata;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] expv [NC];

  always #2.5 clk = ~clk;

  rsb_steered_bank dut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .present_i (present), .powered_i (powered),
    .rvalid_o (rvalid), .rdata_o (rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; v = rvalid;
    req = 1'b0;
  endtask

  task automatic steer(input int g, input int i, input bit mc);
    bus_write(A_SEL, {mc, 19'h0, 4'(g), 4'h0, 4'(i)});
  endtask

  task automatic peek(input int idx, output logic [31:0] d);
    logic v;
    steer(idx / PG, idx % PG, 1'b1);
    bus_read(A_REP, d, v);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int k = 0; k < NC; k++) begin
      peek(k, d);
      check($sformatf("%s copy%0d", tag, k), d, expv[k]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    bus_read(A_SEL, d, v);
    check("R1 selector reset", d, 32'h8000_0000);
    bus_read(A_REP, d, v);
    check("R1 copy0 reset", d, 32'h0);
    for (int k = 0; k < NC; k++) expv[k] = 32'h0;
    check_all("R1 all copies zero");
  endtask

  task automatic t_sel_fields;
    logic [31:0] d; logic v;
    bus_write(A_SEL, 32'h7ABC_F3F1);
    bus_read(A_SEL, d, v);
    check("R2 selector fields, broadcast clear", d, 32'h0000_0301);
    bus_write(A_SEL, 32'hFFFF_F2F0);
    bus_read(A_SEL, d, v);
    check("R2 selector fields, broadcast set", d, 32'h8000_0200);
  endtask

  task automatic t_mcast;
    steer(1, 1, 1'b1);
    bus_write(A_REP, 32'hA5A5_0001);
    for (int k = 0; k < NC; k++) expv[k] = 32'hA5A5_0001;
    check_all("R4 R3 broadcast all live");
  endtask

  task automatic t_unicast;
    logic [31:0] d; logic v;
    steer(2, 1, 1'b0);
    bus_write(A_REP, 32'h0000_1234);
    expv[5] = 32'h0000_1234;
    bus_read(A_REP, d, v);
    check("R3 unicast read of copy5", d, 32'h0000_1234);
    check_all("R6 unicast only target");
  endtask

  task automatic t_mcast_term;
    @(negedge clk);
    present[3] = 1'b0; powered[6] = 1'b0;
    steer(0, 0, 1'b1);
    bus_write(A_REP, 32'h0000_0055);
    @(negedge clk);
    present[3] = 1'b1; powered[6] = 1'b1;
    for (int k = 0; k < NC; k++) if (k != 3 && k != 6) expv[k] = 32'h0000_0055;
    check_all("R5 R11 broadcast skips dead copies");
  endtask

  task automatic t_uni_term;
    logic [31:0] d; logic v;
    @(negedge clk);
    powered[5] = 1'b0;
    steer(2, 1, 1'b0);
    bus_write(A_REP, 32'h0000_0099);
    bus_read(A_REP, d, v);
    check("R8 dead read, broadcast clear", d, 32'h0);
    steer(2, 1, 1'b1);
    bus_read(A_REP, d, v);
    check("R8 dead read, broadcast set", d, 32'h0);
    @(negedge clk);
    powered[5] = 1'b1;
    check_all("R7 R11 dead unicast dropped, value kept");
  endtask

  task automatic t_oob;
    logic [31:0] d; logic v;
    steer(1, 2, 1'b0);
    bus_write(A_REP, 32'h0000_0077);
    bus_read(A_REP, d, v);
    check("R9 instance out of range read", d, 32'h0);
    steer(4, 0, 1'b0);
    bus_write(A_REP, 32'h0000_0088);
    bus_read(A_REP, d, v);
    check("R9 group out of range read", d, 32'h0);
    check_all("R9 out-of-range writes dropped");
  endtask

  task automatic t_bus;
    logic [31:0] d; logic v;
    bus_read(8'h08, d, v);
    check("R10 unmapped read data", d, 32'h0);
    check("R10 rvalid after read", 32'(v), 32'h1);
    @(negedge clk);
    check("R10 rvalid idle", 32'(rvalid), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sel_fields();
    t_mcast();
    t_unicast();
    t_mcast_term();
    t_uni_term();
    t_oob();
    t_bus();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule